// File: doc/BRIEF.md
# Closed-Loop Bias Wiper Step Controller

This block keeps the digital code that sets a gate-bias divider and nudges it one step at a time toward the point where the sensed drain current matches a reference. A comparator outside the block reports whether the current is above the reference. On every serial-clock tick, while chip select is asserted and calibration is enabled, the code moves one step. It goes down when the current is high and up when it is low. Once the loop dithers around its target, a settled flag is raised. The code then stays latched until calibration is run again, either continuously or from time to time.

A shutdown input turns the bias output off but leaves the stored code untouched. When shutdown is released, the same code drives the bias again. Automatic stepping stays locked out until chip select has been dropped and raised once. A parallel load port writes the code directly, standing in for register writes from a serial bus. All logic runs on one system clock. The serial clock arrives as a one-cycle tick strobe in that domain. The asynchronous comparator level is synchronized inside the block.

Top module: `biasWiperStepper`

## Requirements
- R1: Synchronous active-high reset clears the code to 0, clears both direction indicators and the settled flag, and arms the lockout, so ticks are ignored until chip select has gone low and then high.
- R2: A tick that is accepted changes the code on the next clock edge. With `cmpAbove` = 1 (current above reference) the code drops by one. With `cmpAbove` = 0 it rises by one.
- R3: A tick has no effect on the code while `chipSel` is low or `calEn` is low.
- R4: The code saturates: a step up at 255 leaves 255, and a step down at 0 leaves 0.
- R5: While `shutdown` is 1, `biasEnable` is 0 and ticks leave the code unchanged. When shutdown is released, `biasEnable` returns to 1 with the same code.
- R6: After `shutdown` falls, ticks are ignored until `chipSel` has been seen low and then high. Stepping resumes from the clock edge after the one where it is seen high.
- R7: `stepUp`/`stepDown` are never both 1. They show the direction of the most recent accepted step, including a step that saturated, and they hold that value until the next step or a reset.
- R8: `settled` goes to 1 when an accepted step reverses the direction of the previous one. It is cleared when `chipSel` is low or a load occurs.
- R9: `loadStrobe` writes `loadData` into the code on the next edge. It wins over a tick in the same cycle, and that tick then leaves the indicators unchanged.
- R10: `cmpAbove` passes through two flops. A tick taken at the first edge after a change still uses the old comparator value, and a tick at the third edge uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| serialTick | input | 1 | One-cycle strobe per serial clock cycle |
| chipSel | input | 1 | Chip select, active high |
| calEn | input | 1 | Calibration enable |
| cmpAbove | input | 1 | Asynchronous comparator: 1 when current is above reference |
| shutdown | input | 1 | Forces bias off, keeps the code |
| loadStrobe | input | 1 | Direct code write strobe |
| loadData | input | 8 | Code to load |
| wiperCode | output | 8 | Current wiper code |
| biasEnable | output | 1 | 0 while bias is forced to the low rail |
| stepUp | output | 1 | Last step was an increment |
| stepDown | output | 1 | Last step was a decrement |
| settled | output | 1 | Loop has reversed direction |

## Verification
The hardest state to reach is the lockout that comes after shutdown. It is only visible as ticks that do nothing, so the stimulus must release shutdown and fire ticks with chip select held high. It then drops and raises chip select and shows that the very next tick moves the code again. The comparator delay is reached by changing `cmpAbove` in the same cycle as a tick, so the stale value is observed. Saturation is reached by loading the end codes directly instead of stepping 255 times.

// File: rtl/biasStepPkg.sv
package biasStepPkg;
  typedef struct packed {
    logic load;
    logic up;
    logic down;
  } wiperCmd_t;
endpackage

// File: rtl/biasSync.sv
module biasSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= dIn;
      end
    end else begin : gMulti
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/biasStepCtrl.sv
module biasStepCtrl
  import biasStepPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      serialTick,
  input  logic      chipSel,
  input  logic      calEn,
  input  logic      shutdown,
  input  logic      loadStrobe,
  input  logic      cmpAboveSync,
  output wiperCmd_t cmd,
  output logic      stepUp,
  output logic      stepDown,
  output logic      settled
);
  logic lockout;
  logic sawLow;
  logic hasPrev;
  logic prevUp;
  logic stepOk;
  logic stepGo;
  logic dirUp;

  // Current below reference -> raise gate bias.
  assign dirUp  = ~cmpAboveSync;
  assign stepOk = serialTick & chipSel & calEn & ~shutdown & ~lockout;
  assign stepGo = stepOk & ~loadStrobe;

  always_comb begin
    cmd.load = loadStrobe;
    cmd.up   = stepGo & dirUp;
    cmd.down = stepGo & ~dirUp;
  end

  // Chip-select cycle requirement after reset or shutdown.
  always_ff @(posedge clk) begin
    if (rst || shutdown) begin
      lockout <= 1'b1;
      sawLow  <= 1'b0;
    end else if (lockout) begin
      if (!chipSel)    sawLow  <= 1'b1;
      else if (sawLow) lockout <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepUp   <= 1'b0;
      stepDown <= 1'b0;
    end else if (stepGo) begin
      stepUp   <= dirUp;
      stepDown <= ~dirUp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !chipSel || loadStrobe) begin
      settled <= 1'b0;
      hasPrev <= 1'b0;
      prevUp  <= 1'b0;
    end else if (stepGo) begin
      if (hasPrev && (prevUp != dirUp)) settled <= 1'b1;
      hasPrev <= 1'b1;
      prevUp  <= dirUp;
    end
  end
endmodule

// File: rtl/biasWiperPath.sv
module biasWiperPath
  import biasStepPkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  wiperCmd_t         cmd,
  input  logic [CODE_W-1:0] loadData,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic [CODE_W-1:0] codeNext;

  always_comb begin
    codeNext = code;
    if (cmd.load)                           codeNext = loadData;
    else if (cmd.up   && code != CODE_MAX)  codeNext = code + 1'b1;
    else if (cmd.down && code != CODE_MIN)  codeNext = code - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) code <= '0;
    else     code <= codeNext;
  end
endmodule

// File: rtl/biasWiperStepper.sv
module biasWiperStepper
  import biasStepPkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialTick,
  input  logic              chipSel,
  input  logic              calEn,
  input  logic              cmpAbove,
  input  logic              shutdown,
  input  logic              loadStrobe,
  input  logic [CODE_W-1:0] loadData,
  output logic [CODE_W-1:0] wiperCode,
  output logic              biasEnable,
  output logic              stepUp,
  output logic              stepDown,
  output logic              settled
);
  wiperCmd_t cmd;
  logic      cmpAboveSync;

  biasSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rst(rst), .dIn(cmpAbove), .dOut(cmpAboveSync)
  );

  biasStepCtrl uCtrl (
    .clk(clk), .rst(rst), .serialTick(serialTick), .chipSel(chipSel),
    .calEn(calEn), .shutdown(shutdown), .loadStrobe(loadStrobe),
    .cmpAboveSync(cmpAboveSync), .cmd(cmd), .stepUp(stepUp),
    .stepDown(stepDown), .settled(settled)
  );

  biasWiperPath #(.CODE_W(CODE_W)) uPath (
    .clk(clk), .rst(rst), .cmd(cmd), .loadData(loadData), .code(wiperCode)
  );

  assign biasEnable = ~shutdown;
endmodule

// File: rtl/biasWiperStepperChk.sv
module biasWiperStepperChk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              chipSel,
  input logic              shutdown,
  input logic              loadStrobe,
  input logic [CODE_W-1:0] loadData,
  input logic [CODE_W-1:0] wiperCode,
  input logic              stepUp,
  input logic              stepDown,
  input logic              settled
);
  localparam logic [CODE_W-1:0] CMAX = '1;

  a_r4_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
    (wiperCode == CMAX && !loadStrobe) |=> wiperCode != '0);
  a_r4_no_wrap_bottom: assert property (@(posedge clk) disable iff (rst)
    (wiperCode == '0 && !loadStrobe) |=> wiperCode != CMAX);
  a_r3_cs_low_hold: assert property (@(posedge clk) disable iff (rst)
    (!chipSel && !loadStrobe) |=> $stable(wiperCode));
  a_r5_shutdown_hold: assert property (@(posedge clk) disable iff (rst)
    (shutdown && !loadStrobe) |=> $stable(wiperCode));
  a_r9_load_value: assert property (@(posedge clk) disable iff (rst)
    loadStrobe |=> wiperCode == $past(loadData));
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    !loadStrobe |=> (wiperCode == $past(wiperCode)) ||
                    (wiperCode == $past(wiperCode) + 1'b1) ||
                    (wiperCode == $past(wiperCode) - 1'b1));
  a_r7_onehot_dir: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stepUp, stepDown}));
  a_r8_settled_clear: assert property (@(posedge clk) disable iff (rst)
    (!chipSel || loadStrobe) |=> !settled);
endmodule

bind biasWiperStepper biasWiperStepperChk #(.CODE_W(CODE_W)) uChk (
  .clk(clk), .rst(rst), .chipSel(chipSel), .shutdown(shutdown),
  .loadStrobe(loadStrobe), .loadData(loadData), .wiperCode(wiperCode),
  .stepUp(stepUp), .stepDown(stepDown), .settled(settled)
);

// File: tb/biasWiperStepper_test.sv
module biasWiperStepper_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serialTick = 1'b0;
  logic       chipSel = 1'b0;
  logic       calEn = 1'b0;
  logic       cmpAbove = 1'b0;
  logic       shutdown = 1'b0;
  logic       loadStrobe = 1'b0;
  logic [7:0] loadData = '0;
  logic [7:0] wiperCode;
  logic       biasEnable, stepUp, stepDown, settled;
  int nChecks = 0;
  int nFail = 0;

  // 50 MHz
  always #10 clk = ~clk;

  biasWiperStepper uut (
    .clk(clk), .rst(rst), .serialTick(serialTick), .chipSel(chipSel),
    .calEn(calEn), .cmpAbove(cmpAbove), .shutdown(shutdown),
    .loadStrobe(loadStrobe), .loadData(loadData), .wiperCode(wiperCode),
    .biasEnable(biasEnable), .stepUp(stepUp), .stepDown(stepDown),
    .settled(settled)
  );

  // {cmpAbove, expected code} starting from a loaded 100
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'd101}, {1'b0, 8'd102}, {1'b1, 8'd101},
    {1'b1, 8'd100}, {1'b0, 8'd101}, {1'b1, 8'd100}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkCode(input string req, input int exp);
    check(wiperCode == exp, req, wiperCode, exp);
  endtask

  task automatic tick();
    @(negedge clk) serialTick = 1'b1;
    @(negedge clk) serialTick = 1'b0;
  endtask

  task automatic setCmp(input logic v);
    @(negedge clk) cmpAbove = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic loadCode(input logic [7:0] v);
    @(negedge clk) begin loadStrobe = 1'b1; loadData = v; end
    @(negedge clk) loadStrobe = 1'b0;
  endtask

  task automatic csCycle();
    @(negedge clk) chipSel = 1'b0;
    @(negedge clk) chipSel = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    chipSel = 1'b1;
    calEn = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checkCode("R1 code after reset", 0);
    check(!stepUp && !stepDown, "R1 indicators", {stepUp, stepDown}, 0);
    check(!settled, "R1 settled", settled, 0);
    check(biasEnable, "R1 biasEnable", biasEnable, 1);
    tick();
    checkCode("R1 lockout after reset", 0);
    csCycle();
    tick();
    checkCode("R6 step after cs cycle", 1);
    check(stepUp && !stepDown, "R7 up indicator", {stepUp, stepDown}, 2);

    loadCode(8'd100);
    checkCode("R9 load", 100);

    // R2 / R7 table walk
    for (int i = 0; i < 6; i++) begin
      setCmp(VEC[i][8]);
      tick();
      checkCode("R2 table step", int'(VEC[i][7:0]));
      check(stepUp == !VEC[i][8] && stepDown == VEC[i][8], "R7 direction",
            {stepUp, stepDown}, {!VEC[i][8], VEC[i][8]});
    end
    check(settled, "R8 settled after reversal", settled, 1);

    @(negedge clk) chipSel = 1'b0;
    @(negedge clk);
    check(!settled, "R8 settled cleared by cs low", settled, 0);
    tick();
    checkCode("R3 tick with cs low", 100);
    @(negedge clk) begin chipSel = 1'b1; calEn = 1'b0; end
    tick();
    checkCode("R3 tick with calEn low", 100);
    @(negedge clk) calEn = 1'b1;

    // R4 saturation
    loadCode(8'd255);
    setCmp(1'b0);
    tick();
    checkCode("R4 saturate top", 255);
    check(stepUp, "R7 up on saturated step", stepUp, 1);
    loadCode(8'd0);
    setCmp(1'b1);
    tick();
    checkCode("R4 saturate bottom", 0);
    check(stepDown, "R7 down on saturated step", stepDown, 1);

    // R9 load beats tick; indicators unchanged
    setCmp(1'b0);
    @(negedge clk) begin loadStrobe = 1'b1; loadData = 8'd50; serialTick = 1'b1; end
    @(negedge clk) begin loadStrobe = 1'b0; serialTick = 1'b0; end
    checkCode("R9 load priority", 50);
    check(stepDown && !stepUp, "R9 indicators held", {stepUp, stepDown}, 1);

    // R10 synchronizer latency: tick with cmp change uses old value (0 -> up)
    @(negedge clk) begin cmpAbove = 1'b1; serialTick = 1'b1; end
    @(negedge clk) serialTick = 1'b0;
    checkCode("R10 stale comparator", 51);
    repeat (3) @(negedge clk);
    tick();
    checkCode("R10 new comparator", 50);

    // R5 / R6 shutdown
    setCmp(1'b0);
    @(negedge clk) shutdown = 1'b1;
    #1 check(!biasEnable, "R5 biasEnable low", biasEnable, 0);
    tick();
    checkCode("R5 hold in shutdown", 50);
    @(negedge clk) shutdown = 1'b0;
    @(negedge clk);
    check(biasEnable, "R5 biasEnable restored", biasEnable, 1);
    checkCode("R5 code kept", 50);
    tick();
    checkCode("R6 locked after shutdown", 50);
    csCycle();
    tick();
    checkCode("R6 stepping resumes", 51);

    // R1 reset mid-run
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    checkCode("R1 reset clears code", 0);
    check(!stepUp && !stepDown, "R1 reset clears indicators", {stepUp, stepDown}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule